// File: doc/BRIEF.md
# Programmable-Length Serial Shift Register

This block is a serial shift register whose observed length can be set to any value from 1 to 64 bits. A six-bit weighted length code picks the stage that drives the output. The serial input bit comes from one of two data inputs. Because of this, one input can carry fresh data while the other carries the output fed back, so stored data can circulate.

Shifting is driven by a pair of slow external pins, a shift clock and a shift enable. Both pins are oversampled by a fast system clock. A shift happens on a rising shift clock while the enable is low, or on a falling enable while the shift clock is high. A master clear input empties the register asynchronously. The block drives a true output and its complement, both taken from the selected last stage.

Top module: `varlen_shreg`

## Requirements
- R1: The length code `len_i` (bit k has weight 2^k) selects n = `len_i` + 1 stages; `q_o` shows the bit stored n-1 shifts ago, so code 0 gives 1 bit and code 63 gives 64 bits.
- R2: With `sel_a_i` high the shifted-in bit is `data_a_i`; with it low the bit is `data_b_i`.
- R3: A rising `shift_clk_i` while `shift_en_i` is low causes one shift; the result appears at `q_o` on the third `clk_i` rising edge after the pin changes.
- R4: A falling `shift_en_i` while `shift_clk_i` is high causes one shift, with the same latency as R3.
- R5: No other pin transition shifts: a falling `shift_clk_i`, a rising `shift_clk_i` with `shift_en_i` high, and a rising `shift_en_i` all leave the contents unchanged.
- R6: While `clr_i` is high, every stage is zero at once, without waiting for `clk_i`, so `q_o` is low and `q_n_o` is high, and no shift takes effect.
- R7: `q_n_o` is always the complement of `q_o`, including after reset.
- R8: A change of `len_i` moves the output tap in the same cycle and does not alter any stored bit.
- R9: If both shift conditions arise from one simultaneous pin change, exactly one shift is made.
- R10: Holding the pins steady after a qualifying edge gives no further shifts; the internal shift pulse lasts one `clk_i` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the shift pins |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| clr_i | input | 1 | Active-high asynchronous master clear |
| data_a_i | input | 1 | Serial data source A |
| data_b_i | input | 1 | Serial data source B |
| sel_a_i | input | 1 | Source select: 1 = A, 0 = B |
| shift_clk_i | input | 1 | External shift clock pin |
| shift_en_i | input | 1 | External shift enable pin |
| len_i | input | 6 | Weighted length code; length = code + 1 |
| q_o | output | 1 | Bit in the last selected stage |
| q_n_o | output | 1 | Complement of q_o |

## Verification
The two trigger conditions can fall in the same system-clock cycle. This is provoked by driving the shift clock high and the enable low in a single step, so that both synchronized edges arrive together. The result is judged by loading a first stage whose value differs from the new input bit. Only a single shift leaves that old bit in the second stage, while a double shift would overwrite it, so reading length code 1 tells the cases apart. The master clear is also raised mid-cycle while a qualifying shift edge is in flight, which shows that clearing wins over shifting.

// File: rtl/vsr_pkg.sv
package vsr_pkg;
  typedef struct packed {
    logic clk;
    logic en;
  } vsr_pins_t;
endpackage

// File: rtl/vsr_sync.sv
module vsr_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe[s] <= '0;
        else if (s == 0) pipe[s] <= d_i;
        else pipe[s] <= pipe[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/vsr_trig.sv
module vsr_trig
  import vsr_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  vsr_pins_t pins_i,
  output logic      shift_o
);
  vsr_pins_t prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev <= '0;
    else prev <= pins_i;
  end

  logic clk_rise, en_fall;
  assign clk_rise = pins_i.clk & ~prev.clk & ~pins_i.en;
  assign en_fall  = prev.en & ~pins_i.en & pins_i.clk;
  // coincident conditions merge into one pulse
  assign shift_o  = clk_rise | en_fall;
endmodule

// File: rtl/vsr_core.sv
module vsr_core #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned TW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          arst_ni,
  input  logic          shift_i,
  input  logic          din_i,
  input  logic [TW-1:0] tap_i,
  output logic          bit_o
);
  logic [DEPTH-1:0] stg;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) stg <= '0;
    else if (shift_i) stg <= {stg[DEPTH-2:0], din_i};
  end

  assign bit_o = stg[tap_i];
endmodule

// File: rtl/varlen_shreg.sv
module varlen_shreg
  import vsr_pkg::*;
#(
  parameter int unsigned MAX_LEN     = 64,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned LEN_W      = $clog2(MAX_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             data_a_i,
  input  logic             data_b_i,
  input  logic             sel_a_i,
  input  logic             shift_clk_i,
  input  logic             shift_en_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             q_o,
  output logic             q_n_o
);
  vsr_pins_t pins_raw, pins_s;
  logic      shift_en, din, arst_n, tap_bit;

  assign pins_raw = '{clk: shift_clk_i, en: shift_en_i};

  vsr_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  vsr_trig u_trig (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pins_i (pins_s),
    .shift_o(shift_en)
  );

  assign din    = sel_a_i ? data_a_i : data_b_i;
  assign arst_n = rst_ni & ~clr_i;

  vsr_core #(.DEPTH(MAX_LEN)) u_core (
    .clk_i  (clk_i),
    .arst_ni(arst_n),
    .shift_i(shift_en),
    .din_i  (din),
    .tap_i  (len_i),
    .bit_o  (tap_bit)
  );

  assign q_o   = tap_bit;
  assign q_n_o = ~tap_bit;
endmodule

// File: rtl/vsr_chk.sv
module vsr_chk #(
  parameter int unsigned LEN_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic             data_a_i,
  input logic             data_b_i,
  input logic             sel_a_i,
  input logic [LEN_W-1:0] len_i,
  input logic             q_o,
  input logic             q_n_o,
  input logic             shift_en
);
  // R6
  clear_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> (!q_o && q_n_o));

  // R10
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en |=> !shift_en);

  // R5
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_en && !clr_i) |=> (clr_i || !$stable(len_i) || $stable(q_o)));

  // R2
  first_stage_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_en && !clr_i && len_i == '0) |=>
      (clr_i || !$stable(len_i) || q_o == $past(sel_a_i ? data_a_i : data_b_i)));
endmodule

bind varlen_shreg vsr_chk #(.LEN_W(LEN_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .clr_i   (clr_i),
  .data_a_i(data_a_i),
  .data_b_i(data_b_i),
  .sel_a_i (sel_a_i),
  .len_i   (len_i),
  .q_o     (q_o),
  .q_n_o   (q_n_o),
  .shift_en(shift_en)
);

// File: tb/sim_varlen_shreg.sv
module sim_varlen_shreg;
  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0;
  logic da = 1'b0, db = 1'b0, sel = 1'b1, pc = 1'b0, pe = 1'b0;
  logic [5:0] len = '0;
  logic q, qn;
  logic [63:0] m = '0;
  int n_run = 0, n_fail = 0, cyc = 0;
  logic [7:0] lfsr = 8'hA5;

  always #2 clk = ~clk;

  varlen_shreg u0 (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .data_a_i(da), .data_b_i(db),
    .sel_a_i(sel), .shift_clk_i(pc), .shift_en_i(pe), .len_i(len),
    .q_o(q), .q_n_o(qn)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b (len=%0d)", req, act, exp, len);
    end
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  // Drive data for the next shift; the unused source gets the opposite bit.
  task automatic set_data(input logic d, input logic use_a);
    sel = use_a;
    da  = use_a ? d : ~d;
    db  = use_a ? ~d : d;
  endtask

  // Move pins, let them propagate, update model, check output.
  task automatic step(input logic nc, input logic ne, input string req);
    logic rise, fall;
    rise = !pc && nc && !ne;
    fall = pe && !ne && nc;
    @(negedge clk);
    pc = nc; pe = ne;
    repeat (5) @(posedge clk);
    if ((rise || fall) && !clr) m = {m[62:0], sel ? da : db};
    @(negedge clk);
    chk(req, q, m[len]);
    chk("R7", qn, ~m[len]);
  endtask

  task automatic next_bit(output logic b);
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    b = lfsr[0];
  endtask

  initial begin
    logic b;
    repeat (3) @(negedge clk);
    chk("R7", q, 1'b0);
    chk("R7", qn, 1'b1);
    rst_n = 1'b1;

    // Fill: alternate the two trigger styles and the two sources
    for (int i = 0; i < 80; i++) begin
      next_bit(b);
      set_data(b, i[1]);
      len = 6'(i % 3);
      if (i[0] == 1'b0) begin
        step(1'b1, 1'b0, "R3");
        step(1'b0, 1'b0, "R5");
      end else begin
        step(1'b1, 1'b1, "R5");
        step(1'b1, 1'b0, "R4");
        step(1'b0, 1'b0, "R5");
      end
      len = '0;
      @(negedge clk);
      chk("R2", q, b);
    end

    // Length sweep: every tap, no disturbance of data
    for (int n = 0; n < 64; n++) begin
      @(negedge clk); len = 6'(n);
      @(negedge clk);
      chk("R1", q, m[n]);
      chk("R8", qn, ~m[n]);
    end
    for (int n = 63; n >= 0; n--) begin
      @(negedge clk); len = 6'(n);
      @(negedge clk);
      chk("R8", q, m[n]);
    end

    // Non-qualifying moves with opposite data staged at the input
    len = '0;
    set_data(~m[0], 1'b1);
    step(1'b0, 1'b1, "R5");
    step(1'b1, 1'b1, "R5");
    step(1'b0, 1'b1, "R5");
    step(1'b1, 1'b1, "R5");
    step(1'b1, 1'b0, "R4");
    // Long hold: no repeat shift
    set_data(~m[0], 1'b0);
    repeat (50) @(posedge clk);
    @(negedge clk);
    chk("R10", q, m[0]);
    step(1'b0, 1'b0, "R5");

    // Coincident: clock rises while enable falls in the same cycle
    step(1'b0, 1'b1, "R5");
    len = 6'd1;
    set_data(~m[0], 1'b1);
    step(1'b1, 1'b0, "R9");
    len = 6'd0;
    @(negedge clk);
    chk("R9", q, m[0]);

    // Master clear mid-cycle, with a qualifying edge in flight
    for (int i = 0; i < 64; i++) m[i] = i[0];
    len = 6'd63;
    @(negedge clk); #1 clr = 1'b1;
    #0.5 chk("R6", q, 1'b0);
    chk("R6", qn, 1'b1);
    m = '0;
    set_data(1'b1, 1'b1);
    step(1'b0, 1'b0, "R6");
    step(1'b1, 1'b0, "R6");
    @(negedge clk); clr = 1'b0;
    for (int n = 0; n < 64; n++) begin
      @(negedge clk); len = 6'(n);
      @(negedge clk);
      chk("R6", q, 1'b0);
    end

    // Refill after clear through source B
    len = 6'd2;
    for (int i = 0; i < 6; i++) begin
      next_bit(b);
      set_data(b, 1'b0);
      step(1'b0, 1'b0, "R5");
      step(1'b1, 1'b0, "R3");
    end
    report();
  end
endmodule